// File: doc/BRIEF.md
# Answering-Machine Playback Sequencer

This block steers the replay of stored answering-machine messages from front-panel buttons. Each button arrives as a debounced pulse one clock wide. The block also receives the number of stored messages and a strobe that marks the end of the current message. From these inputs it keeps the index of the current message, the replay direction, a replay-active flag and the operating mode. It also issues a one-cycle removal request that carries the index of a message marked for deletion.

There are four operating modes, and one button steps through them in a fixed ring. A single replay button starts replay when the block is idle and reverses the direction while replay runs. Skip and the end-of-message strobe both move one message in the current direction. Replay stops at either end of the message list and does not wrap. A deletion is only recorded while replay runs. It is committed after replay ends, and it can be withdrawn before then by pressing the delete button again. Decoding, audio, display and storage sit outside this block.

Top module: `pb_playback_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, `mode` is 0 (full replay), `playing` is 0, `dir_rev` is 0, `cur_idx` is 0 and `del_req` is 0.
- R2: Each `btn_mode` pulse moves `mode` one step around the ring 0 (full) → 1 (voice only) → 2 (image only) → 3 (call) → 0. The new value is visible in the cycle after the pulse.
- R3: A `btn_play` pulse while idle in modes 0 to 2 starts replay if `msg_count` is non-zero. Replay starts at `cur_idx` 0 with `dir_rev` 0 (forward). If `msg_count` is 0 the pulse has no effect.
- R4: A `btn_play` pulse while replay runs inverts `dir_rev`. It leaves `cur_idx` unchanged and replay keeps running.
- R5: While replay runs, a `btn_skip` pulse or a `msg_done` strobe adds 1 to `cur_idx` when `dir_rev` is 0 and subtracts 1 when `dir_rev` is 1.
- R6: A skip or end-of-message on index `msg_count`-1 while going forward, or on index 0 while going backward, clears `playing`. `cur_idx` keeps its value and does not wrap.
- R7: A `btn_stop` pulse while replay runs clears `playing`.
- R8: A `btn_delete` pulse while replay runs marks the current index. A second pulse before replay ends withdraws the mark, and no `del_req` follows when replay ends.
- R9: When replay ends with a mark held, `del_req` is 1 for exactly one cycle, in the cycle in which `playing` first reads 0. In that cycle `del_idx` equals the marked index, even if `cur_idx` has moved since the mark was set. `del_req` is never raised while replay runs.
- R10: In mode 3 (call), pulses on `btn_play`, `btn_delete`, `btn_skip` and `btn_stop` have no effect, and `playing` stays 0.
- R11: A `btn_mode` pulse while replay runs ends replay, advances the mode, and commits a held mark as in R9.
- R12: While idle, `btn_skip` and `msg_done` leave `cur_idx` and `playing` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_mode | input | 1 | Mode button pulse |
| btn_play | input | 1 | Replay/reverse button pulse |
| btn_delete | input | 1 | Delete/withdraw button pulse |
| btn_skip | input | 1 | Skip button pulse |
| btn_stop | input | 1 | Stop button pulse |
| msg_done | input | 1 | End-of-current-message strobe |
| msg_count | input | CNT_W (5) | Number of stored messages, 0 to MAX_MSGS |
| cur_idx | output | IDX_W (5) | Current message index |
| dir_rev | output | 1 | 0 = forward, 1 = backward |
| playing | output | 1 | Replay active |
| mode | output | 2 | Operating mode: 0 full, 1 voice, 2 image, 3 call |
| del_req | output | 1 | One-cycle removal request |
| del_idx | output | IDX_W (5) | Index to remove, valid while del_req is 1 |

## Verification
The assertions assume that `msg_count` does not change while replay runs, and that at most one button pulse or `msg_done` strobe is high in any cycle. The range assertion on `cur_idx` relies on the first of these assumptions. The stimulus sets `msg_count` only while the block is idle, and each scenario task raises a single input for one cycle and then returns it to zero before it drives the next input.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_VOICE = 2'd1,
        MODE_IMAGE = 2'd2,
        MODE_CALL  = 2'd3
    } pb_mode_e;

    function automatic pb_mode_e pb_next_mode(input pb_mode_e m);
        case (m)
            MODE_FULL:  return MODE_VOICE;
            MODE_VOICE: return MODE_IMAGE;
            MODE_IMAGE: return MODE_CALL;
            default:    return MODE_FULL;
        endcase
    endfunction

endpackage

// File: rtl/pb_mode_sel.sv
module pb_mode_sel
    import pb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    output pb_mode_e mode_o
);
    pb_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (adv) mode_d = pb_next_mode(mode_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FULL;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> mode_q == $past(mode_q));
endmodule

// File: rtl/pb_idx_step.sv
module pb_idx_step #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned CNT_W = 5
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             dir_rev,
    input  logic [CNT_W-1:0] msg_count,
    output logic [IDX_W-1:0] step_idx,
    output logic             at_edge
);
    localparam int unsigned W = (CNT_W > IDX_W) ? CNT_W : IDX_W;

    logic [W-1:0] idx_w;
    logic [W-1:0] last_w;

    always_comb begin
        idx_w  = W'(cur_idx);
        last_w = W'(msg_count) - W'(1);
        if (dir_rev) begin
            at_edge  = (idx_w == '0);
            step_idx = cur_idx - IDX_W'(1);
        end else begin
            at_edge  = (idx_w >= last_w);
            step_idx = cur_idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/pb_del_track.sv
module pb_del_track #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             toggle,
    input  logic             commit,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             del_req,
    output logic [IDX_W-1:0] del_idx
);
    typedef struct packed {
        logic             pending;
        logic [IDX_W-1:0] mark;
        logic             req;
        logic [IDX_W-1:0] req_idx;
    } del_state_t;

    del_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (commit) begin
            if (st_q.pending) begin
                st_d.req     = 1'b1;
                st_d.req_idx = st_q.mark;
            end
            st_d.pending = 1'b0;
        end else if (toggle) begin
            st_d.pending = ~st_q.pending;
            if (!st_q.pending) st_d.mark = cur_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign del_req = st_q.req;
    assign del_idx = st_q.req_idx;

    // R9
    del_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        del_req |=> !del_req);

    // R8
    no_req_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> !del_req);
endmodule

// File: rtl/pb_playback_ctrl.sv
module pb_playback_ctrl
    import pb_pkg::*;
#(
    parameter int unsigned MAX_MSGS = 30,
    parameter int unsigned IDX_W    = $clog2(MAX_MSGS),
    parameter int unsigned CNT_W    = $clog2(MAX_MSGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_mode,
    input  logic             btn_play,
    input  logic             btn_delete,
    input  logic             btn_skip,
    input  logic             btn_stop,
    input  logic             msg_done,
    input  logic [CNT_W-1:0] msg_count,
    output logic [IDX_W-1:0] cur_idx,
    output logic             dir_rev,
    output logic             playing,
    output logic [1:0]       mode,
    output logic             del_req,
    output logic [IDX_W-1:0] del_idx
);
    localparam int unsigned W = (CNT_W > IDX_W) ? CNT_W : IDX_W;

    typedef struct packed {
        logic             playing;
        logic             dir_rev;
        logic [IDX_W-1:0] idx;
    } play_state_t;

    play_state_t st_d, st_q;
    pb_mode_e    mode_q;
    logic [IDX_W-1:0] step_idx;
    logic        at_edge;
    logic        end_play;
    logic        del_toggle;
    logic        in_call;

    pb_mode_sel u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (btn_mode),
        .mode_o (mode_q)
    );

    pb_idx_step #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_step (
        .cur_idx   (st_q.idx),
        .dir_rev   (st_q.dir_rev),
        .msg_count (msg_count),
        .step_idx  (step_idx),
        .at_edge   (at_edge)
    );

    pb_del_track #(.IDX_W(IDX_W)) u_del (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle  (del_toggle),
        .commit  (end_play),
        .cur_idx (st_q.idx),
        .del_req (del_req),
        .del_idx (del_idx)
    );

    assign in_call = (mode_q == MODE_CALL);

    always_comb begin
        st_d       = st_q;
        end_play   = 1'b0;
        del_toggle = 1'b0;
        if (btn_mode) begin
            if (st_q.playing) begin
                st_d.playing = 1'b0;
                end_play     = 1'b1;
            end
        end else if (in_call) begin
            st_d = st_q;
        end else if (btn_stop) begin
            if (st_q.playing) begin
                st_d.playing = 1'b0;
                end_play     = 1'b1;
            end
        end else if (btn_play) begin
            if (st_q.playing) begin
                st_d.dir_rev = ~st_q.dir_rev;
            end else if (msg_count != '0) begin
                st_d.playing = 1'b1;
                st_d.dir_rev = 1'b0;
                st_d.idx     = '0;
            end
        end else if (btn_skip || msg_done) begin
            if (st_q.playing) begin
                if (at_edge) begin
                    st_d.playing = 1'b0;
                    end_play     = 1'b1;
                end else begin
                    st_d.idx = step_idx;
                end
            end
        end else if (btn_delete) begin
            if (st_q.playing) del_toggle = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_idx = st_q.idx;
    assign dir_rev = st_q.dir_rev;
    assign playing = st_q.playing;
    assign mode    = mode_q;

    // R10
    no_play_in_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> !playing);

    // R6
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        playing |-> W'(cur_idx) < W'(msg_count));

    // R9
    del_req_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        del_req |-> (!playing && $past(playing)));

    // R2
    mode_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_mode |=> mode != $past(mode));

    // R4
    reverse_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && btn_play && !btn_mode && !btn_stop)
            |=> (playing && dir_rev != $past(dir_rev) && $stable(cur_idx)));

    // R11
    mode_stops_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_mode |=> !playing);
endmodule

// File: tb/test_pb_playback_ctrl.sv
module test_pb_playback_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_mode = 1'b0, btn_play = 1'b0, btn_delete = 1'b0;
    logic       btn_skip = 1'b0, btn_stop = 1'b0, msg_done = 1'b0;
    logic [4:0] msg_count = '0;
    logic [4:0] cur_idx;
    logic       dir_rev, playing, del_req;
    logic [1:0] mode;
    logic [4:0] del_idx;

    int checks = 0;
    int failures = 0;

    localparam int P_MODE = 0, P_PLAY = 1, P_DEL = 2, P_SKIP = 3, P_STOP = 4, P_DONE = 5;

    always #5 clk = ~clk;

    pb_playback_ctrl i_pb_playback_ctrl (
        .clk(clk), .rst_n(rst_n),
        .btn_mode(btn_mode), .btn_play(btn_play), .btn_delete(btn_delete),
        .btn_skip(btn_skip), .btn_stop(btn_stop), .msg_done(msg_done),
        .msg_count(msg_count),
        .cur_idx(cur_idx), .dir_rev(dir_rev), .playing(playing),
        .mode(mode), .del_req(del_req), .del_idx(del_idx)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // pulse one input for one cycle; outputs are updated when this returns
    task automatic press(input int which);
        @(negedge clk);
        case (which)
            P_MODE: btn_mode   = 1'b1;
            P_PLAY: btn_play   = 1'b1;
            P_DEL:  btn_delete = 1'b1;
            P_SKIP: btn_skip   = 1'b1;
            P_STOP: btn_stop   = 1'b1;
            default: msg_done  = 1'b1;
        endcase
        @(negedge clk);
        btn_mode = 1'b0; btn_play = 1'b0; btn_delete = 1'b0;
        btn_skip = 1'b0; btn_stop = 1'b0; msg_done = 1'b0;
    endtask

    task automatic set_count(input int n);
        @(negedge clk);
        msg_count = 5'(n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mode", int'(mode), 0);
        check("R1 playing", int'(playing), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dir_rev", int'(dir_rev), 0);
        check("R1 cur_idx", int'(cur_idx), 0);
        check("R1 del_req", int'(del_req), 0);
    endtask

    task automatic t_mode_ring();
        press(P_MODE); check("R2 mode step1", int'(mode), 1);
        press(P_MODE); check("R2 mode step2", int'(mode), 2);
        press(P_MODE); check("R2 mode step3", int'(mode), 3);
        press(P_MODE); check("R2 mode wrap", int'(mode), 0);
    endtask

    task automatic t_play_empty();
        set_count(0);
        press(P_PLAY);
        check("R3 empty play ignored", int'(playing), 0);
    endtask

    task automatic t_forward();
        set_count(3);
        press(P_PLAY);
        check("R3 start playing", int'(playing), 1);
        check("R3 start idx", int'(cur_idx), 0);
        check("R3 start dir", int'(dir_rev), 0);
        press(P_SKIP); check("R5 skip fwd", int'(cur_idx), 1);
        press(P_DONE); check("R5 done fwd", int'(cur_idx), 2);
        press(P_SKIP);
        check("R6 end fwd playing", int'(playing), 0);
        check("R6 end fwd no wrap", int'(cur_idx), 2);
    endtask

    task automatic t_reverse();
        set_count(3);
        press(P_PLAY);
        check("R3 restart idx", int'(cur_idx), 0);
        press(P_SKIP);
        press(P_PLAY);
        check("R4 dir flipped", int'(dir_rev), 1);
        check("R4 idx kept", int'(cur_idx), 1);
        check("R4 still playing", int'(playing), 1);
        press(P_SKIP); check("R5 skip back", int'(cur_idx), 0);
        press(P_DONE);
        check("R6 end back playing", int'(playing), 0);
        check("R6 end back no wrap", int'(cur_idx), 0);
    endtask

    task automatic t_stop_idle();
        set_count(4);
        press(P_PLAY);
        press(P_SKIP);
        press(P_STOP);
        check("R7 stop", int'(playing), 0);
        press(P_SKIP);
        check("R12 idle skip idx", int'(cur_idx), 1);
        check("R12 idle skip playing", int'(playing), 0);
        press(P_DONE);
        check("R12 idle done idx", int'(cur_idx), 1);
    endtask

    task automatic t_delete();
        set_count(3);
        press(P_PLAY);
        press(P_SKIP);
        press(P_DEL);
        check("R9 no req while playing", int'(del_req), 0);
        press(P_SKIP);
        check("R9 idx moved", int'(cur_idx), 2);
        press(P_STOP);
        check("R9 req raised", int'(del_req), 1);
        check("R9 marked idx", int'(del_idx), 1);
        @(negedge clk);
        check("R9 req one cycle", int'(del_req), 0);
    endtask

    task automatic t_undelete();
        set_count(3);
        press(P_PLAY);
        press(P_DEL);
        press(P_DEL);
        press(P_STOP);
        check("R8 cancelled no req", int'(del_req), 0);
        @(negedge clk);
        check("R8 cancelled later", int'(del_req), 0);
    endtask

    task automatic t_call();
        set_count(3);
        press(P_MODE); press(P_MODE); press(P_MODE);
        check("R10 in call", int'(mode), 3);
        press(P_PLAY);
        check("R10 play ignored", int'(playing), 0);
        press(P_DEL);
        press(P_STOP);
        check("R10 delete ignored", int'(del_req), 0);
        press(P_MODE);
        check("R10 back to full", int'(mode), 0);
    endtask

    task automatic t_mode_while_playing();
        set_count(3);
        press(P_PLAY);
        press(P_SKIP);
        press(P_DEL);
        press(P_MODE);
        check("R11 stops playing", int'(playing), 0);
        check("R11 mode advanced", int'(mode), 1);
        check("R11 commit req", int'(del_req), 1);
        check("R11 commit idx", int'(del_idx), 1);
        press(P_MODE); press(P_MODE); press(P_MODE);
        check("R2 ring home", int'(mode), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mode_ring();
                t_play_empty();
                t_forward();
                t_reverse();
                t_stop_idle();
                t_delete();
                t_undelete();
                t_call();
                t_mode_while_playing();
            end
            begin
                #1000000;
                checks++;
                failures++;
                $display("FAIL watchdog got=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule